// File: doc/BRIEF.md
# Page-Local Branch Resolver

This block decides, for one decoded instruction, whether control flow leaves the straight-line path of a small 8-bit controller, and where the next fetch starts. It recognises three kinds of jump. The first kind is the family of conditional jumps, which test a flag, a test input or an accumulator bit. The second is the two-byte direct jump. The third is the single-byte indirect jump, whose target byte is fetched from a table. A conditional jump that is taken, and the indirect jump, change only the low byte of the program counter. The current page is kept. Because of this, code placed in the last bytes of a page behaves differently from code placed elsewhere.

The decoder presents the opcode, the second instruction byte, the address of the opcode and the current machine state together with a one-cycle `dec_valid` strobe. One clock later the resolver returns a registered result:
- whether the instruction is a jump;
- whether the jump is taken;
- the next program counter.

Testing the timer flag consumes that flag. The resolver reports this as a one-cycle clear pulse to the timer logic, which is outside this block. For the indirect jump the block drives a table address to program memory with no register in the path. It expects the addressed byte back in the same cycle.

Top module: `br_page_unit`

## Requirements
- R1: While `rst_n` is low, `res_valid`, `res_branch`, `res_taken` and `tf_clr` are 0 and `res_next_pc` is 0.
- R2: Results appear one clock after the cycle in which `dec_valid` is high. `res_valid` is high for exactly that one cycle. `res_branch`, `res_taken` and `res_next_pc` hold their values while `dec_valid` stays low.
- R3: For a taken conditional jump, `res_next_pc` equals {upper PC_W-8 bits of (`pc_cur`+1), `operand`}. The page is the page of the second instruction byte, not the page of the opcode.
- R4: For a conditional jump that is not taken, `res_next_pc` is `pc_cur`+2 modulo 2^PC_W.
- R5: A conditional jump is any opcode whose low nibble is 0x6 and that appears in this list, with its taken condition: 0x16 timer flag set, 0x26 T0 low, 0x36 T0 high, 0x46 T1 low, 0x56 T1 high, 0x76 F1 set, 0x96 accumulator nonzero, 0xB6 F0 set, 0xC6 accumulator zero, 0xD6 input-buffer-full clear, 0xE6 carry clear, 0xF6 carry set.
- R6: An opcode whose bits 4:0 are 10010 is an accumulator bit test. Bits 7:5 give the bit index, and the jump is taken when that accumulator bit is 1.
- R7: `tf_clr` is high one clock after `dec_valid` carries opcode 0x16, whether or not the jump is taken. It is low after every other opcode and in every idle cycle.
- R8: An opcode whose bits 4:0 are 00100 is a direct jump. It is always taken, with target {`pc_cur`[PC_W-1:11], opcode[7:5], `operand`}.
- R9: Opcode 0xB3 is an indirect jump. `tbl_addr` equals {upper PC_W-8 bits of (`pc_cur`+1), `acc`} in the same cycle. The jump is taken, and `res_next_pc` is {that same page, `tbl_data`}.
- R10: Any other opcode gives `res_branch`=0, `res_taken`=0 and `res_next_pc`=`pc_cur`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_valid | input | 1 | Instruction fields are valid this cycle |
| pc_cur | input | PC_W | Address of the opcode byte |
| opcode | input | 8 | First instruction byte |
| operand | input | DW | Second instruction byte |
| acc | input | DW | Accumulator |
| cy | input | 1 | Carry flag |
| f0 | input | 1 | User flag 0 |
| f1 | input | 1 | User flag 1 |
| tf | input | 1 | Timer overflow flag |
| ibf | input | 1 | Host input buffer full |
| t0 | input | 1 | Test input 0 |
| t1 | input | 1 | Test input 1 |
| tbl_data | input | DW | Program memory byte at `tbl_addr` |
| tbl_addr | output | PC_W | Table address for the indirect jump |
| res_valid | output | 1 | Result strobe |
| res_branch | output | 1 | Instruction was a jump |
| res_taken | output | 1 | Jump taken |
| res_next_pc | output | PC_W | Next fetch address |
| tf_clr | output | 1 | Clear pulse for the timer flag |

## Verification
On every cycle the assertions check the following:
- the one-cycle strobe timing;
- that a taken flag is only ever raised on a jump;
- that the timer clear pulse appears exactly after a timer test;
- that a taken conditional jump stays in the page of its second byte;
- the pc+1 and pc+2 fall-through values;
- that the indirect jump always carries the table byte.

Only the bench's sweep can show that each of the 256 opcodes resolves its own condition correctly against varied flag and accumulator patterns. The same applies to the bit number chosen for the accumulator test and to the direct-jump target. The sweep also places opcodes at page ends and at the top of the address space, where the page of the second byte differs from the page of the opcode.

// File: rtl/br_pkg.sv
package br_pkg;

  localparam int OPC_W = 8;

  localparam logic [7:0] OP_TIMER_TEST = 8'h16;
  localparam logic [7:0] OP_TABLE_JMP  = 8'hB3;
  localparam logic [4:0] LOW_BIT_TEST  = 5'b10010;
  localparam logic [4:0] LOW_DIRECT    = 5'b00100;
  localparam logic [3:0] LOW_COND_NIB  = 4'h6;

  typedef enum logic [1:0] {
    BK_NONE,
    BK_COND,
    BK_JMP,
    BK_IND
  } br_kind_e;

  typedef enum logic [3:0] {
    CS_TF,
    CS_T0,
    CS_T1,
    CS_F0,
    CS_F1,
    CS_ZERO,
    CS_IBF,
    CS_CY,
    CS_ABIT
  } cond_sel_e;

  typedef struct packed {
    logic cy;
    logic f0;
    logic f1;
    logic tf;
    logic ibf;
    logic t0;
    logic t1;
  } br_flags_t;

endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output br_kind_e         kind,
  output cond_sel_e        sel,
  output logic             neg
);

  always_comb begin
    kind = BK_NONE;
    sel  = CS_TF;
    neg  = 1'b0;
    if (opcode[4:0] == LOW_BIT_TEST) begin
      kind = BK_COND;
      sel  = CS_ABIT;
    end else if (opcode == OP_TABLE_JMP) begin
      kind = BK_IND;
    end else if (opcode[4:0] == LOW_DIRECT) begin
      kind = BK_JMP;
    end else if (opcode[3:0] == LOW_COND_NIB) begin
      kind = BK_COND;
      case (opcode[7:4])
        4'h1: sel = CS_TF;
        4'h2: begin sel = CS_T0;   neg = 1'b1; end
        4'h3: sel = CS_T0;
        4'h4: begin sel = CS_T1;   neg = 1'b1; end
        4'h5: sel = CS_T1;
        4'h7: sel = CS_F1;
        4'h9: begin sel = CS_ZERO; neg = 1'b1; end
        4'hB: sel = CS_F0;
        4'hC: sel = CS_ZERO;
        4'hD: begin sel = CS_IBF;  neg = 1'b1; end
        4'hE: begin sel = CS_CY;   neg = 1'b1; end
        4'hF: sel = CS_CY;
        default: kind = BK_NONE;
      endcase
    end
  end

endmodule

// File: rtl/br_cond.sv
module br_cond
  import br_pkg::*;
#(
  parameter int DW = 8
) (
  input  cond_sel_e   sel,
  input  logic        neg,
  input  br_flags_t   flags,
  input  logic [DW-1:0] acc,
  input  logic [2:0]  bsel,
  output logic        hit
);

  localparam int NB = (DW < 8) ? DW : 8;

  logic [7:0] abit_vec;
  logic       acc_zero;
  logic       raw;

  // accumulator bits available to the bit test; absent bits read as 0
  genvar gi;
  generate
    for (gi = 0; gi < 8; gi++) begin : g_abit
      if (gi < NB) begin : g_has
        assign abit_vec[gi] = acc[gi];
      end else begin : g_pad
        assign abit_vec[gi] = 1'b0;
      end
    end
  endgenerate

  assign acc_zero = (acc == '0);

  always_comb begin
    case (sel)
      CS_TF:   raw = flags.tf;
      CS_T0:   raw = flags.t0;
      CS_T1:   raw = flags.t1;
      CS_F0:   raw = flags.f0;
      CS_F1:   raw = flags.f1;
      CS_ZERO: raw = acc_zero;
      CS_IBF:  raw = flags.ibf;
      CS_CY:   raw = flags.cy;
      CS_ABIT: raw = abit_vec[bsel];
      default: raw = 1'b0;
    endcase
    hit = raw ^ neg;
  end

endmodule

// File: rtl/br_target.sv
module br_target
  import br_pkg::*;
#(
  parameter int PC_W = 12,
  parameter int DW   = 8
) (
  input  br_kind_e        kind,
  input  logic            taken,
  input  logic [PC_W-1:0] pc_cur,
  input  logic [DW-1:0]   operand,
  input  logic [2:0]      op_hi,
  input  logic [DW-1:0]   acc,
  input  logic [DW-1:0]   tbl_data,
  output logic [PC_W-1:0] next_pc,
  output logic [PC_W-1:0] tbl_addr
);

  localparam int PG_W  = PC_W - DW;
  localparam int JMP_W = DW + 3;

  function automatic logic [PC_W-1:0] pc_plus(input logic [PC_W-1:0] pc,
                                               input int unsigned k);
    return pc + PC_W'(k);
  endfunction

  function automatic logic [PC_W-1:0] in_page(input logic [PG_W-1:0] pg,
                                               input logic [DW-1:0] lo);
    return {pg, lo};
  endfunction

  logic [PC_W-1:0] pc_p1;
  logic [PC_W-1:0] pc_p2;
  logic [PG_W-1:0] page2;
  logic [PC_W-1:0] jmp_tgt;

  assign pc_p1    = pc_plus(pc_cur, 1);
  assign pc_p2    = pc_plus(pc_cur, 2);
  assign page2    = pc_p1[PC_W-1:DW];
  assign tbl_addr = in_page(page2, acc);

  generate
    if (PC_W > JMP_W) begin : g_keep_bank
      assign jmp_tgt = {pc_cur[PC_W-1:JMP_W], op_hi, operand};
    end else begin : g_no_bank
      assign jmp_tgt = PC_W'({op_hi, operand});
    end
  endgenerate

  always_comb begin
    case (kind)
      BK_COND: next_pc = taken ? in_page(page2, operand) : pc_p2;
      BK_JMP:  next_pc = jmp_tgt;
      BK_IND:  next_pc = in_page(page2, tbl_data);
      default: next_pc = pc_p1;
    endcase
  end

endmodule

// File: rtl/br_page_unit.sv
module br_page_unit
  import br_pkg::*;
#(
  parameter int PC_W = 12,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  input  logic [PC_W-1:0] pc_cur,
  input  logic [7:0]      opcode,
  input  logic [DW-1:0]   operand,
  input  logic [DW-1:0]   acc,
  input  logic            cy,
  input  logic            f0,
  input  logic            f1,
  input  logic            tf,
  input  logic            ibf,
  input  logic            t0,
  input  logic            t1,
  input  logic [DW-1:0]   tbl_data,
  output logic [PC_W-1:0] tbl_addr,
  output logic            res_valid,
  output logic            res_branch,
  output logic            res_taken,
  output logic [PC_W-1:0] res_next_pc,
  output logic            tf_clr
);

  br_kind_e        kind;
  cond_sel_e       sel;
  logic            neg;
  logic            cond_hit;
  br_flags_t       flags;
  logic [PC_W-1:0] next_now;

  // named decode events, also observed by the checker
  logic d_cond, d_jmp, d_ind, d_timer_test;
  logic taken_now, branch_now;

  assign flags = '{cy: cy, f0: f0, f1: f1, tf: tf, ibf: ibf, t0: t0, t1: t1};

  br_decode u_dec (
    .opcode (opcode),
    .kind   (kind),
    .sel    (sel),
    .neg    (neg)
  );

  br_cond #(.DW(DW)) u_cond (
    .sel   (sel),
    .neg   (neg),
    .flags (flags),
    .acc   (acc),
    .bsel  (opcode[7:5]),
    .hit   (cond_hit)
  );

  assign d_cond       = (kind == BK_COND);
  assign d_jmp        = (kind == BK_JMP);
  assign d_ind        = (kind == BK_IND);
  assign d_timer_test = (opcode == OP_TIMER_TEST);
  assign branch_now   = d_cond | d_jmp | d_ind;
  assign taken_now    = d_cond ? cond_hit : (d_jmp | d_ind);

  br_target #(.PC_W(PC_W), .DW(DW)) u_tgt (
    .kind     (kind),
    .taken    (taken_now),
    .pc_cur   (pc_cur),
    .operand  (operand),
    .op_hi    (opcode[7:5]),
    .acc      (acc),
    .tbl_data (tbl_data),
    .next_pc  (next_now),
    .tbl_addr (tbl_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_branch  <= 1'b0;
      res_taken   <= 1'b0;
      res_next_pc <= '0;
      tf_clr      <= 1'b0;
    end else begin
      res_valid <= dec_valid;
      tf_clr    <= dec_valid & d_timer_test;
      if (dec_valid) begin
        res_branch  <= branch_now;
        res_taken   <= taken_now;
        res_next_pc <= next_now;
      end
    end
  end

endmodule

// File: rtl/br_page_unit_chk.sv
module br_page_unit_chk
  import br_pkg::*;
#(
  parameter int PC_W = 12,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dec_valid,
  input logic [PC_W-1:0] pc_cur,
  input logic [7:0]      opcode,
  input logic            tf,
  input logic [DW-1:0]   tbl_data,
  input logic            res_valid,
  input logic            res_branch,
  input logic            res_taken,
  input logic [PC_W-1:0] res_next_pc,
  input logic            tf_clr,
  input logic            d_cond,
  input logic            d_jmp,
  input logic            d_ind
);

  logic [PC_W-1:0] pc_inc1;
  logic [PC_W-1:0] pc_inc2;
  logic            none_now;
  logic            jtf_now;
  logic            jtf_set_now;

  assign pc_inc1     = pc_cur + PC_W'(1);
  assign pc_inc2     = pc_cur + PC_W'(2);
  assign none_now    = !d_cond && !d_jmp && !d_ind;
  assign jtf_now     = dec_valid && (opcode == 8'h16);
  assign jtf_set_now = (opcode == 8'h16) && tf;

  p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(dec_valid));

  p_taken_is_jump_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_taken |-> res_branch);

  p_page_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_taken && $past(d_cond))
      |-> res_next_pc[PC_W-1:DW] == $past(pc_inc1[PC_W-1:DW]));

  p_fall_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken && $past(d_cond)) |-> res_next_pc == $past(pc_inc2));

  p_timer_set_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(jtf_set_now)) |-> res_taken);

  p_timer_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tf_clr == $past(jtf_now));

  p_direct_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(d_jmp)) |-> res_taken);

  p_table_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(d_ind))
      |-> (res_taken && res_next_pc[DW-1:0] == $past(tbl_data)));

  p_plain_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(none_now)) |-> (!res_branch && res_next_pc == $past(pc_inc1)));

endmodule

bind br_page_unit br_page_unit_chk #(.PC_W(PC_W), .DW(DW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .dec_valid   (dec_valid),
  .pc_cur      (pc_cur),
  .opcode      (opcode),
  .tf          (tf),
  .tbl_data    (tbl_data),
  .res_valid   (res_valid),
  .res_branch  (res_branch),
  .res_taken   (res_taken),
  .res_next_pc (res_next_pc),
  .tf_clr      (tf_clr),
  .d_cond      (d_cond),
  .d_jmp       (d_jmp),
  .d_ind       (d_ind)
);

// File: tb/br_page_unit_tb_top.sv
`timescale 1ns/1ps
module br_page_unit_tb_top;

  localparam int PC_W = 12;
  localparam int DW   = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            dec_valid;
  logic [PC_W-1:0] pc_cur;
  logic [7:0]      opcode;
  logic [DW-1:0]   operand;
  logic [DW-1:0]   acc;
  logic            cy, f0, f1, tf, ibf, t0, t1;
  logic [DW-1:0]   tbl_data;
  logic [PC_W-1:0] tbl_addr;
  logic            res_valid, res_branch, res_taken, tf_clr;
  logic [PC_W-1:0] res_next_pc;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  // program memory model for the table read
  function automatic logic [7:0] mem_byte(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  assign tbl_data = mem_byte(tbl_addr);

  br_page_unit #(.PC_W(PC_W), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .pc_cur(pc_cur),
    .opcode(opcode), .operand(operand), .acc(acc), .cy(cy), .f0(f0),
    .f1(f1), .tf(tf), .ibf(ibf), .t0(t0), .t1(t1), .tbl_data(tbl_data),
    .tbl_addr(tbl_addr), .res_valid(res_valid), .res_branch(res_branch),
    .res_taken(res_taken), .res_next_pc(res_next_pc), .tf_clr(tf_clr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (op %h pc %h acc %h)",
               tag, act, exp_v, opcode, pc_cur, acc);
    end
  endtask

  // stimulus patterns: {acc, cy, f0, f1, tf, ibf, t0, t1}
  function automatic logic [14:0] pattern(input int k);
    case (k)
      0: return {8'h00, 7'b0000000};
      1: return {8'hFF, 7'b1111111};
      2: return {8'hA5, 7'b1010101};
      3: return {8'h5A, 7'b0101010};
      4: return {8'h01, 7'b1100110};
      5: return {8'h80, 7'b0011001};
      6: return {8'h10, 7'b1001100};
      default: return {8'h00, 7'b0110011};
    endcase
  endfunction

  function automatic logic [11:0] pc_pick(input int i);
    case (i)
      0: return 12'h000;
      1: return 12'h0FE;
      2: return 12'h0FF;
      3: return 12'h7FF;
      4: return 12'hFFE;
      5: return 12'hFFF;
      default: return 12'h234;
    endcase
  endfunction

  initial begin
    dec_valid = 0; pc_cur = '0; opcode = '0; operand = '0; acc = '0;
    {cy, f0, f1, tf, ibf, t0, t1} = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", 32'(res_valid), 0);
    check("R1 branch", 32'(res_branch), 0);
    check("R1 taken", 32'(res_taken), 0);
    check("R1 next_pc", 32'(res_next_pc), 0);
    check("R1 tf_clr", 32'(tf_clr), 0);
    rst_n = 1;

    for (int pi = 0; pi < 7; pi++) begin
      for (int op = 0; op < 256; op++) begin
        for (int k = 0; k < 8; k++) begin
          logic [14:0] pt;
          logic [7:0]  o;
          logic [11:0] pc1, page_base, e_np, e_tba;
          logic        e_br, e_tk, e_clr, is_cond;
          string       tag;
          pt = pattern(k);
          o  = 8'(op);
          @(negedge clk);
          pc_cur  = pc_pick(pi);
          opcode  = o;
          operand = 8'(op * 7 + k * 29 + pi);
          acc     = pt[14:7];
          {cy, f0, f1, tf, ibf, t0, t1} = pt[6:0];
          dec_valid = 1;

          pc1       = pc_cur + 12'd1;
          page_base = {pc1[11:8], 8'h00};
          e_tba     = page_base | {4'h0, acc};
          e_br = 0; e_tk = 0; is_cond = 0;
          e_np = pc_cur + 12'd1;
          tag  = "R10";
          if (o[4:0] == 5'b10010) begin
            is_cond = 1; e_tk = acc[o[7:5]]; tag = "R6";
          end else if (o == 8'hB3) begin
            e_br = 1; e_tk = 1; e_np = page_base | {4'h0, mem_byte(e_tba)}; tag = "R9";
          end else if (o[4:0] == 5'b00100) begin
            e_br = 1; e_tk = 1; e_np = {pc_cur[11], o[7:5], operand}; tag = "R8";
          end else begin
            is_cond = 1;
            case (o)
              8'h16: e_tk = tf;
              8'h26: e_tk = !t0;
              8'h36: e_tk = t0;
              8'h46: e_tk = !t1;
              8'h56: e_tk = t1;
              8'h76: e_tk = f1;
              8'h96: e_tk = (acc != 0);
              8'hB6: e_tk = f0;
              8'hC6: e_tk = (acc == 0);
              8'hD6: e_tk = !ibf;
              8'hE6: e_tk = !cy;
              8'hF6: e_tk = cy;
              default: is_cond = 0;
            endcase
            if (is_cond) tag = e_tk ? "R3/R5" : "R4/R5";
          end
          if (is_cond) begin
            e_br = 1;
            e_np = e_tk ? (page_base | {4'h0, operand}) : pc_cur + 12'd2;
          end
          e_clr = (o == 8'h16);

          #1;
          if (o == 8'hB3) check("R9 tbl_addr", 32'(tbl_addr), 32'(e_tba));

          @(negedge clk);
          dec_valid = 0;
          check(tag, {12'h0, 1'b0, res_valid, res_branch, res_taken, 4'h0, res_next_pc},
                     {12'h0, 1'b0, 1'b1, e_br, e_tk, 4'h0, e_np});
          check("R7 tf_clr", 32'(tf_clr), 32'(e_clr));

          @(negedge clk);
          // R2: idle cycle, strobe drops and results hold
          check("R2 idle", {16'h0, res_valid, tf_clr, res_branch, res_taken, res_next_pc},
                           {16'h0, 1'b0, 1'b0, e_br, e_tk, e_np});
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule